// File: doc/BRIEF.md
# Motor Bridge Fault Supervisor

This block decides, every clock cycle, whether each of two H-bridge output stages may switch or must be held at high impedance. It also drives a shared active-low fault flag meant for an open-drain pin. It reads an external active-low sleep request, one overcurrent comparator flag per bridge, a die over-temperature flag whose hysteresis is applied outside the block, and a supply undervoltage flag.

An overcurrent condition must persist for a programmable deglitch time before it is confirmed. A confirmed overcurrent turns off only the bridge that saw it and starts a timed retry. When the retry ends, that bridge is re-armed and the cycle repeats if the condition is still there. Over-temperature turns both bridges off for as long as its flag is high. Undervoltage and sleep both drive an internal logic reset that clears every timer and fault state. After that reset ends, a wake-up delay passes before any bridge may switch again. The deglitch, retry and wake lengths are parameters counted in clock cycles.

Top module: `hbridge_fault_guard`

## Requirements
- R1: While `rst_n` is low, and afterwards until the sleep input has been seen high and the wake delay has elapsed, `bridge_en` is 2'b00 and `logic_rst` is 1. During the power-on reset `fault_n` is 1.
- R2: `sleep_n_in`, `overtemp_in` and `undervolt_in` act through a two-stage synchronizer. A change driven between edges takes effect on the outputs after the second following rising edge and not after the first.
- R3: Once `logic_rst` falls, `bridge_en` stays 2'b00 for `WAKE_CYC` rising edges and becomes 2'b11 on the next one. An overcurrent flag held high during the wake delay does not count toward the deglitch time.
- R4: An overcurrent flag that is high for at most `DEGLITCH_CYC` consecutive sampled edges has no effect. When it is high for `DEGLITCH_CYC`+1 consecutive edges, that bridge's enable falls after the last of those edges.
- R5: A confirmed overcurrent on one bridge (bit 0 of `ocp_flag` and `bridge_en` for bridge 0, bit 1 for bridge 1) clears only that bridge's enable. The other bridge's enable stays 1.
- R6: From a confirmed overcurrent, `fault_n` is 0 and that bridge is disabled for exactly `RETRY_CYC` cycles. After that the enable returns to 1 and `fault_n` returns to 1, whatever the overcurrent flag is doing during the retry.
- R7: If the overcurrent flag is still high when the retry ends, the bridge is enabled for `DEGLITCH_CYC`+1 cycles and then trips again.
- R8: A synchronized over-temperature flag forces `bridge_en` to 2'b00 and `fault_n` to 0. Both bridges return to enabled, and `fault_n` to 1, two edges after the flag clears, with no wake delay.
- R9: A synchronized undervoltage flag drives `logic_rst` to 1, `bridge_en` to 2'b00 and `fault_n` to 0, and clears any retry in progress. When the flag clears, `fault_n` is 1 and the wake delay of R3 applies.
- R10: While the synchronized sleep input is low, `logic_rst` is 1, `bridge_en` is 2'b00 and `fault_n` is 1, whatever the over-temperature, undervoltage and overcurrent inputs are doing. Retry state is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_n_in | input | 1 | Asynchronous sleep request, 0 = sleep |
| ocp_flag | input | 2 | Per-bridge overcurrent comparator flags, synchronous to clk |
| overtemp_in | input | 1 | Asynchronous over-temperature flag, hysteresis applied outside |
| undervolt_in | input | 1 | Asynchronous supply undervoltage flag |
| bridge_en | output | 2 | Per-bridge switching enable, 0 = high impedance |
| logic_rst | output | 1 | Internal logic reset, held during sleep and undervoltage |
| fault_n | output | 1 | Open-drain fault flag, 0 = pull low, 1 = released |

## Verification
The bench builds the block with a deglitch of 4 cycles, a retry of 40 cycles and a wake delay of 8 cycles. With these short windows, the boundary between a pulse that is ignored and one that trips can be hit on the exact cycle. Repeated trip and retry cycles fit into a few hundred clocks. Because the retry is longer than the synchronizer plus wake path, the bench can also show that undervoltage ends a retry early.

// File: rtl/hbridge_fault_guard.sv
module hbridge_fault_guard #(
  parameter int DEGLITCH_CYC = 64,
  parameter int RETRY_CYC    = 16000,
  parameter int WAKE_CYC     = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_n_in,
  input  logic [1:0] ocp_flag,
  input  logic       overtemp_in,
  input  logic       undervolt_in,
  output logic [1:0] bridge_en,
  output logic       logic_rst,
  output logic       fault_n
);
  localparam int TMAX = (DEGLITCH_CYC > RETRY_CYC) ? DEGLITCH_CYC : RETRY_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int WW   = $clog2(WAKE_CYC + 1);

  logic [2:0] sync1, sync2;
  logic sleep_n_s, ot_s, uv_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {undervolt_in, overtemp_in, sleep_n_in};
      sync2 <= sync1;
    end

  assign sleep_n_s = sync2[0];
  assign ot_s      = sync2[1];
  assign uv_s      = sync2[2];
  assign logic_rst = !sleep_n_s || uv_s;

  logic [WW-1:0] wake_cnt;
  logic          awake;
  assign awake = (wake_cnt == WW'(WAKE_CYC));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         wake_cnt <= '0;
    else if (logic_rst) wake_cnt <= '0;
    else if (!awake)    wake_cnt <= wake_cnt + 1'b1;

  logic [1:0]    retry;
  logic [TW-1:0] tcnt [2];

  for (genvar i = 0; i < 2; i++) begin : g_br
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        retry[i] <= 1'b0;
        tcnt[i]  <= '0;
      end else if (logic_rst) begin
        retry[i] <= 1'b0;
        tcnt[i]  <= '0;
      end else if (retry[i]) begin
        if (tcnt[i] == TW'(RETRY_CYC - 1)) begin
          retry[i] <= 1'b0;
          tcnt[i]  <= '0;
        end else tcnt[i] <= tcnt[i] + 1'b1;
      end else if (!awake || ot_s || !ocp_flag[i]) begin
        tcnt[i] <= '0;
      end else if (tcnt[i] == TW'(DEGLITCH_CYC)) begin
        retry[i] <= 1'b1;
        tcnt[i]  <= '0;
      end else tcnt[i] <= tcnt[i] + 1'b1;

    assign bridge_en[i] = !logic_rst && awake && !ot_s && !retry[i];

    // R4
    trip_needs_deglitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(retry[i]) |-> $past(tcnt[i]) == TW'(DEGLITCH_CYC) && $past(ocp_flag[i]));

    // R5
    trip_local_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bridge_en[i]) && !logic_rst && !ot_s |-> $past(ocp_flag[i]));
  end

  assign fault_n = !sleep_n_s || !(uv_s || ot_s || (|retry));

  // R3
  wake_before_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|bridge_en) |-> $past(!logic_rst));

  // R3
  wake_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_cnt <= WW'(WAKE_CYC));

  // R10
  sleep_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(logic_rst) |-> retry == 2'b00 && wake_cnt == '0);

  // R10
  sleep_fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sleep_n_s) && !sleep_n_s |-> fault_n);
endmodule

// File: tb/hbridge_fault_guard_test.sv
module hbridge_fault_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int DG = 4;
  localparam int RT = 40;
  localparam int WK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_n_in = 1'b1;
  logic [1:0] ocp_flag = 2'b00;
  logic overtemp_in = 1'b0;
  logic undervolt_in = 1'b0;
  logic [1:0] bridge_en;
  logic logic_rst, fault_n;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_fault_guard #(.DEGLITCH_CYC(DG), .RETRY_CYC(RT), .WAKE_CYC(WK)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_n_in(sleep_n_in), .ocp_flag(ocp_flag),
    .overtemp_in(overtemp_in), .undervolt_in(undervolt_in),
    .bridge_en(bridge_en), .logic_rst(logic_rst), .fault_n(fault_n));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] en, input logic lr, input logic fn);
    checks++;
    if (bridge_en !== en || logic_rst !== lr || fault_n !== fn) begin
      errors++;
      $display("FAIL %s: en=%b rst=%b fault_n=%b expected en=%b rst=%b fault_n=%b",
               req, bridge_en, logic_rst, fault_n, en, lr, fn);
    end
  endtask

  task automatic t_reset_wake;
    chk("R1 in reset", 2'b00, 1'b1, 1'b1);
    cyc(1); rst_n = 1'b1;
    cyc(1);
    chk("R2 one edge", 2'b00, 1'b1, 1'b1);
    cyc(1);
    chk("R1 sync done", 2'b00, 1'b0, 1'b1);
    cyc(WK - 1);
    chk("R3 wake not over", 2'b00, 1'b0, 1'b1);
    cyc(1);
    chk("R3 wake over", 2'b11, 1'b0, 1'b1);
  endtask

  task automatic t_deglitch;
    ocp_flag = 2'b01; cyc(DG); ocp_flag = 2'b00;
    chk("R4 short pulse", 2'b11, 1'b0, 1'b1);
    cyc(1);
    chk("R4 short pulse after", 2'b11, 1'b0, 1'b1);
    ocp_flag = 2'b01; cyc(DG + 1); ocp_flag = 2'b00;
    chk("R4 R5 trip bridge0", 2'b10, 1'b0, 1'b0);
    cyc(RT - 1);
    chk("R6 retry end-1", 2'b10, 1'b0, 1'b0);
    cyc(1);
    chk("R6 retry end", 2'b11, 1'b0, 1'b1);
  endtask

  task automatic t_repeat;
    ocp_flag = 2'b10; cyc(DG + 1);
    chk("R5 trip bridge1", 2'b01, 1'b0, 1'b0);
    cyc(RT);
    chk("R7 re-enabled", 2'b11, 1'b0, 1'b1);
    cyc(DG);
    chk("R7 re-deglitch", 2'b11, 1'b0, 1'b1);
    cyc(1);
    chk("R7 trips again", 2'b01, 1'b0, 1'b0);
    ocp_flag = 2'b00; cyc(RT);
    chk("R7 clear", 2'b11, 1'b0, 1'b1);
  endtask

  task automatic t_overtemp;
    overtemp_in = 1'b1; cyc(1);
    chk("R2 ot one edge", 2'b11, 1'b0, 1'b1);
    cyc(1);
    chk("R8 ot active", 2'b00, 1'b0, 1'b0);
    cyc(5);
    overtemp_in = 1'b0; cyc(2);
    chk("R8 ot resume", 2'b11, 1'b0, 1'b1);
  endtask

  task automatic t_undervolt;
    ocp_flag = 2'b01; cyc(DG + 1); ocp_flag = 2'b00;
    chk("R9 pre trip", 2'b10, 1'b0, 1'b0);
    undervolt_in = 1'b1; cyc(2);
    chk("R9 uv active", 2'b00, 1'b1, 1'b0);
    cyc(3);
    undervolt_in = 1'b0; cyc(2);
    chk("R9 retry cleared", 2'b00, 1'b0, 1'b1);
    cyc(WK);
    chk("R9 R3 resumed", 2'b11, 1'b0, 1'b1);
  endtask

  task automatic t_sleep;
    ocp_flag = 2'b01; cyc(DG + 1);
    sleep_n_in = 1'b0; overtemp_in = 1'b1; undervolt_in = 1'b1; ocp_flag = 2'b11;
    cyc(2);
    chk("R10 sleep", 2'b00, 1'b1, 1'b1);
    cyc(10);
    chk("R10 sleep ignores", 2'b00, 1'b1, 1'b1);
    overtemp_in = 1'b0; undervolt_in = 1'b0; sleep_n_in = 1'b1;
    cyc(2 + WK);
    chk("R3 ocp ignored in wake", 2'b11, 1'b0, 1'b1);
    cyc(DG);
    chk("R4 deglitch after wake", 2'b11, 1'b0, 1'b1);
    cyc(1);
    chk("R5 both trip", 2'b00, 1'b0, 1'b0);
    ocp_flag = 2'b00; cyc(RT);
    chk("R6 both recover", 2'b11, 1'b0, 1'b1);
  endtask

  initial begin
    cyc(2);
    t_reset_wake();
    t_deglitch();
    t_repeat();
    t_overtemp();
    t_undervolt();
    t_sleep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule